// File: doc/BRIEF.md
# CPU-Cycle Down-Count Interrupt Timer

This block is a 16-bit interrupt timer. It counts processor cycles and raises a level interrupt request when a programmed number of cycles has passed. A strobe input pulses once per processor cycle and clocks the count. Software reaches the timer through a byte-wide write port that carries an address.

To use the timer, software stores the 16-bit start value in two halves, one byte per write. A separate write copies that value into the live counter. A control write turns the timer on. The counter then counts down once per cycle strobe and flags the interrupt at the moment it reaches zero. After that it stays at zero and does not wrap or restart. Software clears the request either with another control write or with a fresh copy of the start value.

A four-state controller holds the timer's mode:

- `ST_OFF`: timer disabled.
- `ST_RUN`: enabled, counter non-zero.
- `ST_PARKED`: enabled, counter at zero, nothing pending.
- `ST_FIRED`: enabled, counter at zero, request pending.

Its transitions:

- **off** (control write with bit 7 clear): any state goes to `ST_OFF`.
- **on** (control write with bit 7 set): any state goes to `ST_RUN` if the counter is non-zero, otherwise to `ST_PARKED`.
- **rearm** (copy write while enabled): goes to `ST_RUN` if the start value is non-zero, otherwise to `ST_PARKED`.
- **expire** (`ST_RUN` with a tick while the counter equals 1): goes to `ST_FIRED`.

A copy write while in `ST_OFF` keeps the state.

Top module: `cyc_irq_timer`

## Requirements
- R1: A write to address 0x9005 stores the data byte as bits 15:8 of the start value, and a write to 0x9006 stores it as bits 7:0. Each of these writes leaves the other byte unchanged.
- R2: A write to 0x9004 copies the start value into the counter and clears a pending request. The data byte of this write has no effect.
- R3: A write to 0x9003 clears a pending request and sets the enable to data bit 7 (1 = counting on).
- R4: While enabled, each tick lowers the counter by one. With a start value N ≥ 1, `irq_pending` is low through the first N-1 ticks and goes high at the clock edge that takes the Nth tick.
- R5: Once at zero the counter stays at zero, and `irq_pending` stays high until a write to 0x9003 or 0x9004.
- R6: After reset, the enable, the pending request, the counter and the start value are all zero, and `irq_pending` is low.
- R7: While disabled, ticks neither change the counter nor set the request.
- R8: Only a tick that takes the counter from 1 to 0 sets the request. Copying a zero start value, or ticking at zero after a clear, never sets it.
- R9: When a write to one of the four addresses above lands in the same cycle as a tick, the write takes effect and that tick is dropped.
- R10: Writes to any other address change nothing, and a tick in the same cycle is still counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| cpu_tick | input | 1 | One-cycle pulse per processor cycle |
| irq_pending | output | 1 | Level interrupt request |

## Verification
The checks assume one write per clock cycle, a tick lasting a single clock, and inputs that hold no X once reset is released. The stimulus changes inputs only on the falling edge. Every step drives all inputs to defined values, with the write strobe and the tick low when they are unused. Collisions between a tick and a write are created on purpose, one per step, so the priority rule is exercised for each kind of write and for an unmapped address.

// File: rtl/cyc_irq_pkg.sv
`timescale 1ns/1ps
package cyc_irq_pkg;

    // Controller states of the timer
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RUN    = 2'd1,
        ST_PARKED = 2'd2,
        ST_FIRED  = 2'd3
    } tmr_state_e;

    localparam logic [15:0] DEF_ADDR_CTRL = 16'h9003;
    localparam logic [15:0] DEF_ADDR_ARM  = 16'h9004;
    localparam logic [15:0] DEF_ADDR_HI   = 16'h9005;
    localparam logic [15:0] DEF_ADDR_LO   = 16'h9006;

endpackage

// File: rtl/cyc_irq_regs.sv
`timescale 1ns/1ps
module cyc_irq_regs
    import cyc_irq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(DEF_ADDR_CTRL),
    parameter logic [ADDR_W-1:0] ADDR_ARM  = ADDR_W'(DEF_ADDR_ARM),
    parameter logic [ADDR_W-1:0] ADDR_HI   = ADDR_W'(DEF_ADDR_HI),
    parameter logic [ADDR_W-1:0] ADDR_LO   = ADDR_W'(DEF_ADDR_LO),
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ctrl_wr,
    output logic              ctrl_on,
    output logic              arm_wr,
    output logic              any_hit,
    output logic [CNT_W-1:0]  reload_val,
    output logic              reload_zero
);

    localparam int LANES = CNT_W / DATA_W;

    logic [CNT_W-1:0] reload_q;
    logic [LANES-1:0] lane_wr;

    // One storage lane per byte of the start value; lane 0 is the low byte
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [ADDR_W-1:0] LANE_ADDR = (g == 0) ? ADDR_LO : ADDR_HI;
        assign lane_wr[g] = wr_en && (wr_addr == LANE_ADDR);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reload_q[g*DATA_W +: DATA_W] <= '0;
            end else if (lane_wr[g]) begin
                reload_q[g*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    always_comb begin
        ctrl_wr     = wr_en && (wr_addr == ADDR_CTRL);
        arm_wr      = wr_en && (wr_addr == ADDR_ARM);
        ctrl_on     = wr_data[DATA_W-1];
        any_hit     = ctrl_wr || arm_wr || (|lane_wr);
        reload_val  = reload_q;
        reload_zero = (reload_q == '0);
    end

    // R1
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_HI) |=> $stable(reload_q[DATA_W-1:0]));
    // R1
    lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_LO) |=> $stable(reload_q[CNT_W-1:DATA_W]));
    // R10
    foreign_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && (wr_addr == ADDR_HI || wr_addr == ADDR_LO))) |=> $stable(reload_q));

endmodule

// File: rtl/cyc_irq_count.sv
`timescale 1ns/1ps
module cyc_irq_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             cnt_zero,
    output logic             cnt_one
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_comb begin
        cnt_zero = (cnt_q == '0);
        cnt_one  = (cnt_q == CNT_W'(1));
    end

    // R5
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |=> cnt_q == '0);
    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && !$stable(cnt_q)) |-> cnt_q == $past(cnt_q) - CNT_W'(1));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !load) |=> $stable(cnt_q));
    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));

endmodule

// File: rtl/cyc_irq_fsm.sv
`timescale 1ns/1ps
module cyc_irq_fsm
    import cyc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_tick,
    input  logic any_hit,
    input  logic ctrl_wr,
    input  logic ctrl_on,
    input  logic arm_wr,
    input  logic reload_zero,
    input  logic cnt_zero,
    input  logic cnt_one,
    output logic dec_en,
    output logic pending
);

    tmr_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: writes win over ticks
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            if (!ctrl_on) begin
                state_d = ST_OFF;
            end else if (cnt_zero) begin
                state_d = ST_PARKED;
            end else begin
                state_d = ST_RUN;
            end
        end else if (arm_wr) begin
            unique case (state_q)
                ST_OFF:                        state_d = ST_OFF;
                ST_RUN, ST_PARKED, ST_FIRED:   state_d = reload_zero ? ST_PARKED : ST_RUN;
                default:                       state_d = ST_OFF;
            endcase
        end else if (cpu_tick && !any_hit) begin
            unique case (state_q)
                ST_RUN:    state_d = cnt_one ? ST_FIRED : ST_RUN;
                ST_OFF:    state_d = ST_OFF;
                ST_PARKED: state_d = ST_PARKED;
                ST_FIRED:  state_d = ST_FIRED;
                default:   state_d = ST_OFF;
            endcase
        end
    end

    // Outputs
    always_comb begin
        dec_en  = 1'b0;
        pending = 1'b0;
        unique case (state_q)
            ST_RUN:    dec_en  = cpu_tick && !any_hit;
            ST_FIRED:  pending = 1'b1;
            ST_OFF, ST_PARKED: ;
            default: ;
        endcase
    end

    // R8
    rise_on_last_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> ($past(cpu_tick) && $past(cnt_one) && !$past(any_hit)));
    // R5
    fall_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> ($past(ctrl_wr) || $past(arm_wr)));
    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr || arm_wr) |=> !pending);
    // R9
    hit_blocks_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> !dec_en);

endmodule

// File: rtl/cyc_irq_timer.sv
`timescale 1ns/1ps
module cyc_irq_timer
    import cyc_irq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(DEF_ADDR_CTRL),
    parameter logic [ADDR_W-1:0] ADDR_ARM  = ADDR_W'(DEF_ADDR_ARM),
    parameter logic [ADDR_W-1:0] ADDR_HI   = ADDR_W'(DEF_ADDR_HI),
    parameter logic [ADDR_W-1:0] ADDR_LO   = ADDR_W'(DEF_ADDR_LO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cpu_tick,
    output logic              irq_pending
);

    localparam int CNT_W = 2 * DATA_W;

    logic             ctrl_wr, ctrl_on, arm_wr, any_hit, reload_zero;
    logic [CNT_W-1:0] reload_val;
    logic             cnt_zero, cnt_one, dec_en;

    cyc_irq_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ADDR_CTRL(ADDR_CTRL), .ADDR_ARM(ADDR_ARM),
        .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl_wr(ctrl_wr), .ctrl_on(ctrl_on), .arm_wr(arm_wr),
        .any_hit(any_hit), .reload_val(reload_val), .reload_zero(reload_zero)
    );

    cyc_irq_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n),
        .load(arm_wr), .load_val(reload_val), .dec(dec_en),
        .cnt_zero(cnt_zero), .cnt_one(cnt_one)
    );

    cyc_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick),
        .any_hit(any_hit), .ctrl_wr(ctrl_wr), .ctrl_on(ctrl_on),
        .arm_wr(arm_wr), .reload_zero(reload_zero),
        .cnt_zero(cnt_zero), .cnt_one(cnt_one),
        .dec_en(dec_en), .pending(irq_pending)
    );

    // R6
    reset_quiet_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> !irq_pending);

endmodule

// File: tb/cyc_irq_timer_test.sv
`timescale 1ns/1ps
module cyc_irq_timer_test;

    localparam logic [15:0] A_CTRL = 16'h9003;
    localparam logic [15:0] A_ARM  = 16'h9004;
    localparam logic [15:0] A_HI   = 16'h9005;
    localparam logic [15:0] A_LO   = 16'h9006;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cpu_tick = 1'b0;
    logic        irq_pending;

    int checks = 0;
    int errors = 0;

    // Reference state kept from the requirements
    logic [15:0] m_rel = '0;
    logic [15:0] m_cnt = '0;
    logic        m_en = 1'b0;
    logic        m_pend = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    cyc_irq_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cpu_tick(cpu_tick), .irq_pending(irq_pending)
    );

    // Driver: one clock per step, expected result pushed to the scoreboard
    task automatic step(input bit w, input logic [15:0] a, input logic [7:0] d,
                        input bit t, input string tag);
        bit hit;
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; cpu_tick = t;
        hit = w && (a == A_CTRL || a == A_ARM || a == A_HI || a == A_LO);
        if (hit) begin
            if (a == A_HI) m_rel[15:8] = d;
            if (a == A_LO) m_rel[7:0] = d;
            if (a == A_ARM) begin m_cnt = m_rel; m_pend = 1'b0; end
            if (a == A_CTRL) begin m_en = d[7]; m_pend = 1'b0; end
        end else if (t && m_en && m_cnt != 16'd0) begin
            m_cnt = m_cnt - 16'd1;
            if (m_cnt == 16'd0) m_pend = 1'b1;
        end
        exp_q.push_back(m_pend);
        tag_q.push_back(tag);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        step(1'b1, a, d, 1'b0, tag);
    endtask

    task automatic tk(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0, 8'h0, 1'b1, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0, 8'h0, 1'b0, tag);
    endtask

    // Monitor: compares each registered result just after the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() != 0) begin
            bit    e;
            string g;
            e = exp_q.pop_front();
            g = tag_q.pop_front();
            checks++;
            if (irq_pending !== e) begin
                errors++;
                $display("FAIL %s: irq_pending=%b expected=%b at %0t", g, irq_pending, e, $time);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (irq_pending !== 1'b0) begin
            errors++;
            $display("FAIL R6: irq_pending=%b expected=0 during reset", irq_pending);
        end
        rst_n = 1'b1;
        // R6: quiet after reset; ticks with zero state do nothing
        idle(2, "R6");
        tk(3, "R6");
        // R1, R4: start value 5, exact tick count
        wr(A_HI, 8'h00, "R1"); wr(A_LO, 8'h05, "R1");
        wr(A_ARM, 8'h00, "R2"); wr(A_CTRL, 8'h80, "R3");
        tk(5, "R4");
        // R5: holds at zero, stays pending
        tk(10, "R5");
        idle(3, "R5");
        // R3 ack keeps enabled; R8 no re-arm at zero
        wr(A_CTRL, 8'h80, "R3");
        tk(6, "R8");
        // R1 byte independence: HI=1, LO=2, HI=0 leaves 0x0002
        wr(A_HI, 8'h01, "R1"); wr(A_LO, 8'h02, "R1"); wr(A_HI, 8'h00, "R1");
        wr(A_ARM, 8'hFF, "R2");
        tk(3, "R1");
        // R2: copy write clears pending and restarts
        wr(A_ARM, 8'h5A, "R2");
        tk(2, "R2");
        // R3: disable clears; R7: disabled ticks ignored
        wr(A_CTRL, 8'h7F, "R3");
        wr(A_ARM, 8'h00, "R7");
        tk(6, "R7");
        wr(A_CTRL, 8'h80, "R7");
        tk(2, "R7");
        // R9: collisions with each kind of write
        wr(A_LO, 8'h03, "R9"); wr(A_ARM, 8'h00, "R9");
        tk(1, "R9");
        step(1'b1, A_LO, 8'h03, 1'b1, "R9");
        step(1'b1, A_HI, 8'h00, 1'b1, "R9");
        tk(1, "R9");
        step(1'b1, A_ARM, 8'h00, 1'b1, "R9");
        tk(2, "R9");
        step(1'b1, A_CTRL, 8'h80, 1'b1, "R9");
        tk(1, "R9");
        // R10: unmapped writes change nothing and do not block ticks
        wr(A_ARM, 8'h00, "R10");
        step(1'b1, 16'h9007, 8'h80, 1'b1, "R10");
        step(1'b1, 16'h9002, 8'h00, 1'b1, "R10");
        tk(1, "R10");
        idle(1, "R10");
        // R8: zero start value never fires
        wr(A_HI, 8'h00, "R8"); wr(A_LO, 8'h00, "R8"); wr(A_ARM, 8'h00, "R8");
        tk(5, "R8");
        // R4 with high byte: 0x0104 ticks
        wr(A_HI, 8'h01, "R4"); wr(A_LO, 8'h04, "R4"); wr(A_ARM, 8'h00, "R4");
        tk(261, "R4");
        idle(2, "R5");
        @(posedge clk); #2;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule